// File: doc/BRIEF.md
# I2C Register Target with Strap-Selected Address

This block is the serial front end of a 16-pin port expander. It watches an I2C bus whose SCL and SDA lines have already been synchronised to the system clock, and it pulls SDA low through an open-drain enable when it acknowledges or sends a zero. Its 7-bit device address comes from three strap inputs. The top strap has two levels. The other two straps each have four classes, decoded upstream, and this gives 32 possible addresses.

A write transaction holds the address byte with direction 0, then a command byte that loads the register pointer, then any number of data bytes. To read, the controller writes the command byte, issues a repeated start, and sends the address with direction 1. The block then returns register bytes, MSB first, until the controller NACKs. After each data byte the pointer steps up by one. The block reaches the register bank through a one-cycle write strobe and a one-cycle read strobe. A read strobe lets the bank apply side effects such as clear-on-read.

The state machine has the states IDLE, ADDR (address byte in), ADDR_ACK, CMD (command byte in), CMD_ACK, WDATA (data byte in), WDATA_ACK, TX (data byte out) and RX_ACK (controller acknowledge). It moves as follows:
- IDLE goes to ADDR on a start.
- ADDR goes to ADDR_ACK on a matching address. On a mismatch it goes back to IDLE.
- ADDR_ACK goes to TX for a read and to CMD for a write.
- CMD goes to CMD_ACK, and CMD_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate for as long as the controller sends bytes.
- TX goes to RX_ACK after eight bits.
- RX_ACK goes back to TX on an ACK and to IDLE on a NACK.
- A stop from any state leads to IDLE. A start from any state leads to ADDR.

Top module: `i2c_strap_target`

## Requirements
- R1: A stop (SDA rising while SCL is high) releases SDA and returns the block to idle. A start (SDA falling while SCL is high) in any state releases SDA and restarts address reception. An unfinished byte is then discarded and the register pointer keeps its value.
- R2: Strap codes are 0 = tied low, 1 = tied high, 2 = tied to SCL and 3 = tied to SDA. The device address is {N, top, mid[0], low[0]}. N is 4'b0010 when only the middle strap is tied to a bus line. N is 4'b0011 when both are tied to bus lines. N is 4'b0100 when neither is. N is 4'b0101 when only the low strap is tied to a bus line.
- R3: The first byte after a start holds the address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). A matching address is ACKed. Any other address is NACKed and ignored until the next start.
- R4: In a write, the byte after the address is ACKed and loads the register pointer.
- R5: Each write data byte is ACKed. It gives one single-cycle reg_wr with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then increments.
- R6: After a repeated start and the address with direction 1, the block sends bytes MSB first. Each bit changes only while SCL is low. Each byte is fetched with one single-cycle reg_rd at the pointer, and the pointer then increments. A controller ACK continues the read and a NACK ends it.
- R7: Offsets 0x00, 0x01, 0x0E and 0x0F are read-only. Data bytes sent to them are ACKed, produce no reg_wr, and still advance the pointer.
- R8: Offsets above 0x15 produce no strobe of either kind. A read byte from such an offset is 0x00.
- R9: After reset SDA is released and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_top | input | 1 | Two-level address strap (0 low, 1 high) |
| strap_mid | input | 2 | Middle four-class strap code |
| strap_low | input | 2 | Low four-class strap code |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, combinational from reg_addr |

## Verification
The assertions assume a well-formed controller. SCL and SDA hold steady for several system clocks between edges. SDA changes only while SCL is low, except when forming a start or a stop. The straps do not move during a transaction. The bench's controller tasks keep a few clocks between every line change. They change data one clock after SCL falls and never let a SCL edge coincide with a SDA edge. Strap values are changed only while the bus is idle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'd0,
        STRAP_HIGH = 2'd1,
        STRAP_SCL  = 2'd2,
        STRAP_SDA  = 2'd3
    } strap_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_RX_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_addr_decode.sv
module i2c_tgt_addr_decode
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              top_i,
    input  logic [1:0]        mid_i,
    input  logic [1:0]        low_i,
    output logic [ADDR_W-1:0] dev_addr_o
);
    logic       mid_bus;
    logic       low_bus;
    logic [3:0] prefix;

    // Bit 1 of a strap code marks a bus-line tie; bit 0 gives the address bit.
    assign mid_bus = (strap_e'(mid_i) == STRAP_SCL) || (strap_e'(mid_i) == STRAP_SDA);
    assign low_bus = (strap_e'(low_i) == STRAP_SCL) || (strap_e'(low_i) == STRAP_SDA);

    always_comb begin
        unique case ({mid_bus, low_bus})
            2'b10:   prefix = 4'b0010;
            2'b11:   prefix = 4'b0011;
            2'b00:   prefix = 4'b0100;
            default: prefix = 4'b0101;
        endcase
    end

    assign dev_addr_o = ADDR_W'({prefix, top_i, mid_i[0], low_i[0]});
endmodule

// File: rtl/i2c_tgt_bus_cond.sv
module i2c_tgt_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i && !scl_q;
    assign scl_fall_o = !scl_i && scl_q;
    assign start_o    = scl_i && scl_q && sda_q && !sda_i;
    assign stop_o     = scl_i && scl_q && !sda_q && sda_i;
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
    import i2c_tgt_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          ADDR_W   = 7,
    parameter int          LAST_REG = 21,
    parameter logic [31:0] RO_MASK  = 32'h0000_C003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              strap_top,
    input  logic [1:0]        strap_mid,
    input  logic [1:0]        strap_low,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int          CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] LAST_OFF = DATA_W'(LAST_REG);

    tgt_state_e        state, nxt;
    logic [DATA_W-1:0] shreg, txreg, ptr;
    logic [CNT_W-1:0]  cnt;
    logic              rw, nack;
    logic [ADDR_W-1:0] dev_addr;
    logic              scl_rise, scl_fall, start_c, stop_c;
    logic              byte_done, addr_hit, ptr_ok, ptr_wr_ok, load_ev;

    i2c_tgt_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .top_i      (strap_top),
        .mid_i      (strap_mid),
        .low_i      (strap_low),
        .dev_addr_o (dev_addr)
    );

    i2c_tgt_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    assign byte_done = (cnt == BITS_FULL) && scl_fall;
    assign addr_hit  = (shreg[DATA_W-1:1] == dev_addr);
    assign ptr_ok    = (ptr <= LAST_OFF);
    assign ptr_wr_ok = ptr_ok && !RO_MASK[ptr[4:0]];
    assign load_ev   = scl_fall && (((state == S_ADDR_ACK) && rw) ||
                                    ((state == S_RX_ACK) && !nack));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_c) begin
            nxt = S_IDLE;
        end else if (start_c) begin
            nxt = S_ADDR;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_ADDR:      if (byte_done) nxt = addr_hit ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK:  if (scl_fall)  nxt = rw ? S_TX : S_CMD;
                S_CMD:       if (byte_done) nxt = S_CMD_ACK;
                S_CMD_ACK:   if (scl_fall)  nxt = S_WDATA;
                S_WDATA:     if (byte_done) nxt = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall)  nxt = S_WDATA;
                S_TX:        if (scl_fall && cnt == BITS_LAST) nxt = S_RX_ACK;
                S_RX_ACK:    if (scl_fall)  nxt = nack ? S_IDLE : S_TX;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // Datapath: shift registers, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            txreg <= '0;
            ptr   <= '0;
            cnt   <= '0;
            rw    <= 1'b0;
            nack  <= 1'b1;
        end else if (start_c || stop_c) begin
            cnt <= '0;
        end else if (load_ev) begin
            txreg <= ptr_ok ? reg_rdata : '0;
            ptr   <= ptr + 1'b1;
            cnt   <= '0;
        end else begin
            unique case (state)
                S_ADDR, S_CMD, S_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sda_i};
                        cnt   <= cnt + 1'b1;
                    end
                    if (byte_done) begin
                        cnt <= '0;
                        if (state == S_ADDR)  rw  <= shreg[0];
                        if (state == S_CMD)   ptr <= shreg;
                        if (state == S_WDATA) ptr <= ptr + 1'b1;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        txreg <= {txreg[DATA_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                S_RX_ACK: begin
                    if (scl_rise) nack <= sda_i;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            S_ADDR_ACK, S_CMD_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_TX:                               sda_oe = !txreg[DATA_W-1];
            default:                            sda_oe = 1'b0;
        endcase
        reg_wr    = (state == S_WDATA) && byte_done && ptr_wr_ok;
        reg_rd    = load_ev && ptr_ok;
        reg_addr  = ptr;
        reg_wdata = shreg;
    end
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
    parameter int          DATA_W   = 8,
    parameter int          LAST_REG = 21,
    parameter logic [31:0] RO_MASK  = 32'h0000_C003
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_oe,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_addr
);
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe); // R1
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R5
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd)); // R6
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && ($past(sda_i) == $past(sda_i, 2)))
        |-> $stable(sda_oe)); // R6
    AST_WR_NOT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !((reg_addr < 32) && RO_MASK[reg_addr[4:0]])); // R7
    AST_STROBE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> (reg_addr <= DATA_W'(LAST_REG))); // R8
endmodule

bind i2c_strap_target i2c_strap_target_chk #(
    .DATA_W(DATA_W), .LAST_REG(LAST_REG), .RO_MASK(RO_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe   (sda_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/i2c_strap_target_bench.sv
`timescale 1ns/1ps
module i2c_strap_target_bench;
    localparam int Q = 3;
    localparam int NREG = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_d = 1'b1;
    logic       sda_d = 1'b1;
    logic       sda_ln;
    logic       sda_oe;
    logic       strap_top = 1'b0;
    logic [1:0] strap_mid = 2'd0;
    logic [1:0] strap_low = 2'd0;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] bank [NREG];
    int         wr_cnt, rd_cnt;
    logic [7:0] last_rd;
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] rbuf [8];

    always #4 clk = ~clk;

    assign sda_ln = sda_d & ~sda_oe;
    assign reg_rdata = (reg_addr < NREG) ? bank[reg_addr[4:0]] : 8'hAA;

    i2c_strap_target u_i2c_strap_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_ln), .sda_oe(sda_oe),
        .strap_top(strap_top), .strap_mid(strap_mid), .strap_low(strap_low),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(8'h40 + i * 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank[i] <= init_val(i);
            wr_cnt  <= 0;
            rd_cnt  <= 0;
            last_rd <= 8'hFF;
        end else begin
            if (reg_wr) begin
                wr_cnt <= wr_cnt + 1;
                if (reg_addr < NREG) bank[reg_addr[4:0]] <= reg_wdata;
            end
            if (reg_rd) begin
                rd_cnt  <= rd_cnt + 1;
                last_rd <= reg_addr;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_d = 1'b1; tick(Q);
        scl_d = 1'b1; tick(Q);
        sda_d = 1'b0; tick(Q);
        scl_d = 1'b0; tick(1);
    endtask

    task automatic bus_stop();
        sda_d = 1'b0; tick(Q);
        scl_d = 1'b1; tick(Q);
        sda_d = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_d = b[i]; tick(Q);
            scl_d = 1'b1; tick(Q);
            scl_d = 1'b0; tick(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_d = 1'b1; tick(Q);
        scl_d = 1'b1; tick(1);
        acked = (sda_ln == 1'b0);
        tick(Q - 1);
        scl_d = 1'b0; tick(1);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_d = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_d = 1'b1; tick(1);
            b[i] = sda_ln;
            tick(Q - 1);
            scl_d = 1'b0; tick(1);
        end
        sda_d = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_d = 1'b1; tick(Q);
        scl_d = 1'b0; tick(1);
        sda_d = 1'b1;
    endtask

    function automatic logic [6:0] exp_addr(logic t, logic [1:0] m, logic [1:0] l);
        logic [3:0] p;
        if (m >= 2 && l < 2)       p = 4'd2;
        else if (m >= 2)           p = 4'd3;
        else if (l < 2)            p = 4'd4;
        else                       p = 4'd5;
        return {p, t, m[0], l[0]};
    endfunction

    task automatic write_regs(input logic [6:0] a, input logic [7:0] cmd,
                              input logic [7:0] d0, input logic [7:0] d1, input int n);
        bit ak;
        bus_start();
        send_byte({a, 1'b0}, ak); check(ak, "R3 addr ack", ak, 1);
        send_byte(cmd, ak);       check(ak, "R4 cmd ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(i == 0 ? d0 : d1, ak);
            check(ak, "R5 data ack", ak, 1);
        end
        bus_stop();
    endtask

    task automatic read_regs(input logic [6:0] a, input logic [7:0] cmd, input int n);
        bit ak;
        logic [7:0] b;
        bus_start();
        send_byte({a, 1'b0}, ak); check(ak, "R3 addr ack", ak, 1);
        send_byte(cmd, ak);       check(ak, "R4 cmd ack", ak, 1);
        bus_start();
        send_byte({a, 1'b1}, ak); check(ak, "R6 read addr ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [6:0] da;
        bit ak;
        int w0, r0;
        tick(5);
        check(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R9 reset outputs",
              {sda_oe, reg_wr, reg_rd}, 0);
        rst_n = 1'b1;
        tick(4);
        check(sda_oe == 1'b0, "R9 idle after reset", sda_oe, 0);

        // Sweep all 32 strap settings: match is ACKed, near-miss is NACKed.
        for (int c = 0; c < 32; c++) begin
            strap_top = c[4];
            strap_mid = c[3:2];
            strap_low = c[1:0];
            tick(2);
            da = exp_addr(strap_top, strap_mid, strap_low);
            w0 = wr_cnt;
            write_regs(da, 8'h08, 8'(c), 8'h00, 1);
            check(bank[8] == 8'(c), "R2 strap address write", bank[8], c);
            bus_start();
            send_byte({da ^ 7'h01, 1'b0}, ak);
            check(!ak, "R3 mismatch nack", ak, 0);
            send_byte(8'h09, ak);
            check(!ak && sda_oe == 1'b0, "R3 ignored after mismatch", ak, 0);
            bus_stop();
            check(wr_cnt == w0 + 1, "R3 no write after mismatch", wr_cnt, w0 + 1);
        end

        strap_top = 1'b1; strap_mid = 2'd3; strap_low = 2'd1;
        tick(2);
        da = exp_addr(strap_top, strap_mid, strap_low);

        // R5: auto-incrementing writes
        w0 = wr_cnt;
        write_regs(da, 8'h02, 8'h11, 8'h22, 3);
        check(bank[2] == 8'h11 && bank[3] == 8'h22 && bank[4] == 8'h22,
              "R5 auto-increment write", {bank[2], bank[3], bank[4]}, 24'h112222);
        check(wr_cnt == w0 + 3, "R5 write strobe count", wr_cnt, w0 + 3);

        // R6: read with repeated start
        r0 = rd_cnt;
        read_regs(da, 8'h02, 3);
        check(rbuf[0] == 8'h11 && rbuf[1] == 8'h22 && rbuf[2] == 8'h22, "R6 read data",
              {rbuf[0], rbuf[1], rbuf[2]}, 24'h112222);
        check(rd_cnt == r0 + 3 && last_rd == 8'h04, "R6 read strobes", rd_cnt, r0 + 3);
        tick(2);
        check(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);

        // R7: read-only offsets
        w0 = wr_cnt;
        write_regs(da, 8'h00, 8'h99, 8'h98, 2);
        write_regs(da, 8'h0D, 8'h77, 8'h66, 4);
        check(wr_cnt == w0 + 2, "R7 read-only no strobe", wr_cnt, w0 + 2);
        check(bank[16] == 8'h66 && bank[13] == 8'h77, "R7 pointer advanced past RO",
              {bank[13], bank[16]}, 16'h7766);
        read_regs(da, 8'h00, 2);
        check(rbuf[0] == init_val(0) && rbuf[1] == init_val(1), "R7 RO value kept",
              {rbuf[0], rbuf[1]}, {init_val(0), init_val(1)});
        read_regs(da, 8'h0E, 2);
        check(rbuf[0] == init_val(14) && rbuf[1] == init_val(15), "R7 RO high kept",
              {rbuf[0], rbuf[1]}, {init_val(14), init_val(15)});

        // R8: beyond last offset
        w0 = wr_cnt;
        write_regs(da, 8'h15, 8'h5C, 8'h3D, 2);
        check(wr_cnt == w0 + 1 && bank[21] == 8'h5C, "R8 write past end ignored",
              wr_cnt, w0 + 1);
        r0 = rd_cnt;
        read_regs(da, 8'h14, 3);
        check(rbuf[0] == bank[20] && rbuf[1] == 8'h5C && rbuf[2] == 8'h00,
              "R8 read past end zero", rbuf[2], 0);
        check(rd_cnt == r0 + 2, "R8 no read strobe past end", rd_cnt, r0 + 2);

        // R1: stop in the middle of a data byte
        w0 = wr_cnt;
        bus_start();
        send_byte({da, 1'b0}, ak);
        send_byte(8'h0A, ak);
        send_bits(8'hF0, 4);
        bus_stop();
        tick(2);
        check(sda_oe == 1'b0 && wr_cnt == w0, "R1 stop mid-byte", wr_cnt, w0);

        // R1: start in the middle of a data byte, then read from retained pointer
        bus_start();
        send_byte({da, 1'b0}, ak);
        send_byte(8'h06, ak);
        send_bits(8'h0F, 4);
        bus_start();
        send_byte({da, 1'b1}, ak);
        check(ak, "R1 restart address ack", ak, 1);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        check(rbuf[0] == init_val(6) && wr_cnt == w0, "R1 partial byte discarded",
              rbuf[0], init_val(6));
        read_regs(da, 8'h0A, 1);
        check(rbuf[0] == init_val(10), "R1 stop left register alone", rbuf[0], init_val(10));

        finish_run();
    end
endmodule